// File: doc/BRIEF.md
# External Bus Chip-Select Setup Timer

This block sequences one access at a time on a simple external memory bus. An internal requester offers a read or a write together with an address; once the controller is idle it takes the request, puts the address and the write-enable level on the bus, waits a number of bus clocks, pulls the active-low chip select low for a single clock, releases it, and signals completion with a one-clock done pulse.

The wait between the address appearing and chip select going low is the address setup. Its base length comes from a 2-bit configuration field: the field value plus one clock. A write that directly follows another write (with no read in between) gets one extra setup clock. A read resets that history, and reads themselves always run with the base setup. After reset the history is empty, so the first write uses the base setup.

Top module: `cs_setup_timer`

## Requirements
- R1: After reset, bus_cs_n is 1, req_ready is 1, done is 0, and the write history is clear, so the first write uses the base setup.
- R2: The base setup is setup_cfg + 1 clocks: bus_cs_n falls setup_cfg + 1 rising edges after the edge that accepts the request (cfg 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4). setup_cfg is sampled at acceptance.
- R3: A write accepted while the previous accepted access was a write uses base setup + 1 clocks.
- R4: Accepting a read clears the write history, so the next write uses the base setup.
- R5: A read always uses the base setup, whatever accesses preceded it.
- R6: bus_cs_n is low for exactly one clock per access.
- R7: bus_addr and bus_we_n (0 for a write, 1 for a read) are taken at acceptance and stay stable until bus_cs_n deasserts.
- R8: done is high for exactly one clock, in the clock right after the chip-select clock; req_ready is low from acceptance until after that clock, so bus_cs_n is high for at least one clock between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_cfg | input | SETUP_W | Address setup field, sampled at acceptance |
| req_valid | input | 1 | Requester offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_ready | output | 1 | Controller idle, request accepted on this edge if valid |
| bus_addr | output | ADDR_W | Bus address |
| bus_we_n | output | 1 | Active-low write enable |
| bus_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-clock completion pulse |

## Verification
Single writes are run at every setup field value after a read, which separates the base count for each setting and catches an off-by-one in the counter. Runs of writes show the extra clock appearing from the second write on and not stacking further. Write, write, read, write sequences tell apart a history that a read clears from one that persists, and show reads ignoring history. Every access also checks the one-clock strobe, the done pulse placement and the held address and write-enable level.

// File: rtl/cs_setup_pkg.sv
package cs_setup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_RECOV  = 2'd3
    } phase_e;

endpackage

// File: rtl/cs_setup_calc.sv
module cs_setup_calc #(
    parameter int SETUP_W = 2,
    localparam int CNT_W  = SETUP_W + 1
) (
    input  logic [SETUP_W-1:0] cfg,
    input  logic               is_write,
    input  logic               wr_hist,
    output logic [CNT_W-1:0]   cnt_init
);

    // Count loaded is setup length minus one: cfg, plus one for a repeat write.
    logic extra;

    always_comb begin
        extra    = is_write & wr_hist;
        cnt_init = CNT_W'(cfg) + CNT_W'(extra);
    end

endmodule

// File: rtl/cs_write_hist.sv
module cs_write_hist (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic is_write,
    output logic wr_hist
);

    logic hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (accept) begin
            hist_d = is_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign wr_hist = hist_q;

endmodule

// File: rtl/cs_setup_timer.sv
module cs_setup_timer
    import cs_setup_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SETUP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] setup_cfg,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_we_n,
    output logic               bus_cs_n,
    output logic               done
);

    localparam int CNT_W = SETUP_W + 1;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              we_n;
        logic              cs_n;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept;
    logic             wr_hist;
    logic [CNT_W-1:0] cnt_init;

    assign req_ready = (ctl_q.phase == ST_IDLE);
    assign accept    = req_ready & req_valid;

    cs_write_hist u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_write (req_write),
        .wr_hist  (wr_hist)
    );

    cs_setup_calc #(.SETUP_W(SETUP_W)) u_calc (
        .cfg      (setup_cfg),
        .is_write (req_write),
        .wr_hist  (wr_hist),
        .cnt_init (cnt_init)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.phase = ST_SETUP;
                    ctl_d.cnt   = cnt_init;
                    ctl_d.addr  = req_addr;
                    ctl_d.we_n  = ~req_write;
                end
            end
            ST_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = ST_STROBE;
                    ctl_d.cs_n  = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                ctl_d.phase = ST_RECOV;
                ctl_d.cs_n  = 1'b1;
                ctl_d.done  = 1'b1;
            end
            ST_RECOV: begin
                ctl_d.phase = ST_IDLE;
                ctl_d.we_n  = 1'b1;
            end
            default: ctl_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.addr  <= '0;
            ctl_q.we_n  <= 1'b1;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_addr = ctl_q.addr;
    assign bus_we_n = ctl_q.we_n;
    assign bus_cs_n = ctl_q.cs_n;
    assign done     = ctl_q.done;

endmodule

// File: rtl/cs_setup_timer_chk.sv
module cs_setup_timer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we_n,
    input logic              bus_cs_n,
    input logic              done
);

    // R1: chip select never low while idle
    a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);

    // R6: strobe lasts one clock
    a_r6_strobe_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |=> bus_cs_n);

    // R7: address and write enable held during the access
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_we_n)));

    // R8: done is a single pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows the strobe clock
    a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!bus_cs_n));

    // R2: chip select falls only after at least one setup clock
    a_r2_setup_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> $past(!req_ready));

endmodule

bind cs_setup_timer cs_setup_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_we_n  (bus_we_n),
    .bus_cs_n  (bus_cs_n),
    .done      (done)
);

// File: tb/cs_setup_timer_tb.sv
module cs_setup_timer_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    setup_cfg = 2'd0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic [AW-1:0] bus_addr;
    logic          bus_we_n;
    logic          bus_cs_n;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cs_setup_timer #(.ADDR_W(AW), .SETUP_W(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_cfg (setup_cfg),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .bus_addr  (bus_addr),
        .bus_we_n  (bus_we_n),
        .bus_cs_n  (bus_cs_n),
        .done      (done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One access; checks setup length, strobe, done and held bus values.
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] cfg,
                          input int exp_setup, input string req);
        int k;
        bit held;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; setup_cfg = cfg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; setup_cfg = ~cfg; req_write = ~wr;
        k = 0; held = 1'b1;
        while (bus_cs_n && k < 12) begin
            if (bus_addr != a || bus_we_n != !wr || req_ready) held = 1'b0;
            k++;
            @(negedge clk);
        end
        check(req, k, exp_setup);
        if (bus_addr != a || bus_we_n != !wr) held = 1'b0;
        check("R7 held", int'(held), 1);
        check("R8 no done at strobe", int'(done), 0);
        @(negedge clk);
        check("R6 cs released", int'(bus_cs_n), 1);
        check("R8 done pulse", int'(done), 1);
        check("R8 busy in done clk", int'(req_ready), 0);
        @(negedge clk);
        check("R8 done single", int'(done), 0);
        check("R8 cs high gap", int'(bus_cs_n), 1);
    endtask

    task automatic t_reset();
        check("R1 cs_n", int'(bus_cs_n), 1);
        check("R1 ready", int'(req_ready), 1);
        check("R1 done", int'(done), 0);
        access(1'b1, 16'h0100, 2'd0, 1, "R1 first write base");
    endtask

    task automatic t_base_all_cfg();
        for (int c = 0; c < 4; c++) begin
            access(1'b0, 16'h0200 + 16'(c), 2'(c), c + 1, "R5 read base");
            access(1'b1, 16'h0300 + 16'(c), 2'(c), c + 1, "R2 write base");
        end
    endtask

    task automatic t_consec();
        access(1'b0, 16'h1000, 2'd0, 1, "R5 read base");
        access(1'b1, 16'h1001, 2'd0, 1, "R2 first write cfg0");
        access(1'b1, 16'h1002, 2'd0, 2, "R3 second write cfg0");
        access(1'b1, 16'h1003, 2'd0, 2, "R3 third write cfg0");
        access(1'b0, 16'h1004, 2'd1, 2, "R5 read after writes");
        access(1'b1, 16'h1005, 2'd1, 2, "R4 write after read cfg1");
        access(1'b1, 16'h1006, 2'd1, 3, "R3 second write cfg1");
        access(1'b1, 16'h1007, 2'd3, 5, "R3 repeat write cfg3");
    endtask

    task automatic t_read_clears();
        access(1'b1, 16'hA000, 2'd2, 4, "R3 repeat write cfg2");
        access(1'b0, 16'hA001, 2'd2, 3, "R5 read ignores history");
        access(1'b0, 16'hA002, 2'd2, 3, "R5 read after read");
        access(1'b1, 16'hA003, 2'd2, 3, "R4 history cleared");
        access(1'b1, 16'hA004, 2'd2, 4, "R3 history rebuilt");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_all_cfg();
        t_consec();
        t_read_clears();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule